// File: doc/BRIEF.md
# Watchdog Timer with External Reset Routing

This block is a 16-bit register-mapped watchdog. It counts down in units of a slow 32 kHz tick and, if software does not service it in time, it fires. A routing bit decides whether the timeout raises an internal chip reset or pulls an active-low pin meant for an external power-management device low. The slow clock arrives as a plain input. It is resynchronised into the bus clock domain, and its rising edges become single-cycle tick pulses, so the whole block runs on the bus clock.

Software can also take direct control. One bit drives the external reset pin low at once. A second bit requests an internal reset, which is only granted on the next slow tick. An enable bit and a pre-timeout count arm an interrupt that fires a programmable number of steps before expiry. A separate boot-time watchdog counts from reset and pulls the external pin low after a fixed time unless software turns it off first. The main and boot watchdogs count independently of each other.

Register map, word-addressed on `addr_i`:
- Address 0 is the control register. Bit 0 is the enable, bit 1 routes the timeout to the external pin, bit 2 is the active-low external-pin drive, bit 3 is the active-low software reset request, and bits 15:8 hold the timeout.
- Address 1 is the service register.
- Address 2 is the interrupt register. Bit 15 is the interrupt enable, bit 14 is the status, and bits 7:0 hold the pre-timeout count.
- Address 3 holds the boot-watchdog enable in bit 0.

Top module: `wdg_extrst`

## Requirements
- R1: After reset `int_rst_o`=0, `ext_rst_n_o`=1 and `irq_o`=0. The control register reads 16'h000C (enable 0, routing 0, bit 2=1, bit 3=1, timeout 0). Address 3 reads 16'h0001.
- R2: With the enable set and routing 0, `int_rst_o` rises after (T+1)×STEP_TICKS slow ticks from the enabling write, where T is bits 15:8. `ext_rst_n_o` stays high. `int_rst_o` stays high until reset.
- R3: With routing 1, a timeout drives `ext_rst_n_o` low and leaves `int_rst_o` at 0. The pin stays low until reset.
- R4: Writing 16'h5555 and then 16'hAAAA to address 1 while the enable is set reloads the count with T. Regular servicing prevents the timeout.
- R5: Any other write to address 1 between the two keys cancels the pair, and the following 16'hAAAA does not reload the count.
- R6: Writing bit 2 of the control register as 0 drives `ext_rst_n_o` low one cycle later, whatever the count. Writing it back to 1 releases the pin unless a reset event holds it.
- R7: Writing bit 3 of the control register as 0 raises `int_rst_o` on the next slow tick, not earlier. Repeated identical writes are accepted.
- R8: The enable (bit 0) and routing (bit 1) bits can only be set once. A write of 0 leaves them at 1 until reset.
- R9: The status bit is set at the step where the remaining count equals the pre-timeout count P (bits 7:0 of address 2). When bit 15 is set, `irq_o` follows the status bit. With P=0, `irq_o` and `int_rst_o` rise in the same cycle.
- R10: Writing 1 to status bit 14 clears the status bit and `irq_o`, and they stay low until the next pre-timeout event.
- R11: While bit 0 of address 3 is 1, the boot watchdog pulls `ext_rst_n_o` low after BOOT_TICKS slow ticks from reset. Writing 0 stops it for good: a later write of 1 reads back 0, and the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | 32 kHz slow clock, asynchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; data appears the next cycle |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| int_rst_o | output | 1 | Internal chip reset request, active high, sticky |
| ext_rst_n_o | output | 1 | External reset pin, active low |
| irq_o | output | 1 | Pre-timeout interrupt |

## Verification
The countdown is exercised in several ways:
- Left unserviced, it is checked on both sides of the expected expiry, once per routing setting, which separates the internal path from the external pin.
- It is serviced with correct key pairs, to show that a reload postpones expiry.
- It is given a pair broken by a stray value, where it must expire on the original schedule.

The pre-timeout interrupt is tried with a non-zero count, where it must precede the reset, and with a zero count, where both must rise together. The boot watchdog is run both left alone and switched off, and the software reset request is issued just after a slow tick to show that it waits for the next one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 16;
  localparam int TMO_W  = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SVC  = 2'd1,
    REG_IRQ  = 2'd2,
    REG_MISC = 2'd3
  } wdg_reg_e;

  localparam logic [DATA_W-1:0] SVC_KEY_A = 16'h5555;
  localparam logic [DATA_W-1:0] SVC_KEY_B = 16'hAAAA;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_ROUTE = 1;
  localparam int CTRL_PIN_N = 2;
  localparam int CTRL_SRQ_N = 3;
  localparam int IRQ_ENA    = 15;
  localparam int IRQ_STAT   = 14;
  localparam int MISC_BOOT  = 0;

  typedef struct packed {
    logic             en;
    logic             route;
    logic             pin_n;
    logic [TMO_W-1:0] tmo;
    logic             ie;
    logic [TMO_W-1:0] pre;
    logic             boot_on;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_tick_sync.sv
module wdg_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_i,
  output logic tick_o
);
  logic [SYNC_STAGES:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh_q[g] <= 1'b0;
        else if (g == 0) sh_q[g] <= slow_i;
        else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign tick_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              pre_evt_i,
  output wdg_cfg_t          cfg_o,
  output logic              load_o,
  output logic              srq_fire_o,
  output logic              stat_o
);
  logic             en_q, route_q, pin_n_q, srq_q, ie_q, stat_q, boot_q, armed_q;
  logic [TMO_W-1:0] tmo_q, pre_q;
  logic             wr_ctrl, wr_svc, wr_irq, wr_misc;

  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_svc  = wr_en_i && (addr_i == REG_SVC);
  assign wr_irq  = wr_en_i && (addr_i == REG_IRQ);
  assign wr_misc = wr_en_i && (addr_i == REG_MISC);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      route_q <= 1'b0;
      pin_n_q <= 1'b1;
      srq_q   <= 1'b0;
      tmo_q   <= '0;
    end else if (wr_ctrl) begin
      en_q    <= en_q | wdata_i[CTRL_EN];
      route_q <= route_q | wdata_i[CTRL_ROUTE];
      pin_n_q <= wdata_i[CTRL_PIN_N];
      srq_q   <= srq_q | ~wdata_i[CTRL_SRQ_N];
      tmo_q   <= wdata_i[DATA_W-1 -: TMO_W];
    end
  end

  // Service key sequencer and reload pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (wr_ctrl && wdata_i[CTRL_EN] && !en_q) load_o <= 1'b1;
      if (wr_svc) begin
        if (wdata_i == SVC_KEY_A) armed_q <= 1'b1;
        else begin
          armed_q <= 1'b0;
          if (wdata_i == SVC_KEY_B && armed_q && en_q) load_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      pre_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_irq) begin
        ie_q  <= ie_q | wdata_i[IRQ_ENA];
        pre_q <= wdata_i[TMO_W-1:0];
      end
      if (pre_evt_i) stat_q <= 1'b1;
      else if (wr_irq && wdata_i[IRQ_STAT]) stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) boot_q <= 1'b1;
    else if (wr_misc) boot_q <= boot_q & wdata_i[MISC_BOOT];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        REG_CTRL: rdata_o <= {tmo_q, 4'b0, ~srq_q, pin_n_q, route_q, en_q};
        REG_SVC:  rdata_o <= '0;
        REG_IRQ:  rdata_o <= {ie_q, stat_q, {(DATA_W-TMO_W-2){1'b0}}, pre_q};
        default:  rdata_o <= {{(DATA_W-1){1'b0}}, boot_q};
      endcase
    end
  end

  assign srq_fire_o = srq_q & tick_i;
  assign stat_o     = stat_q;
  assign cfg_o      = '{en: en_q, route: route_q, pin_n: pin_n_q, tmo: tmo_q,
                        ie: ie_q, pre: pre_q, boot_on: boot_q};

  a_r8_en_once: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wdata_i[CTRL_EN] && cfg_o.en) |=> cfg_o.en);
  a_r8_route_once: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wdata_i[CTRL_ROUTE] && cfg_o.route) |=> cfg_o.route);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int TMO_W      = 8,
  parameter int STEP_TICKS = 16384
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic [TMO_W-1:0] pre_i,
  output logic             timeout_o,
  output logic             pre_evt_o
);
  localparam int PW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [PW-1:0] PS_LAST = PW'(STEP_TICKS - 1);

  logic [PW-1:0]    ps_q;
  logic [TMO_W-1:0] cnt_q;
  logic             dead_q, step;

  assign step = tick_i && en_i && !dead_q && (ps_q == PS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q      <= '0;
      cnt_q     <= '0;
      dead_q    <= 1'b0;
      timeout_o <= 1'b0;
      pre_evt_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      pre_evt_o <= 1'b0;
      if (load_i && !dead_q) begin
        ps_q  <= '0;
        cnt_q <= tmo_i;
      end else if (tick_i && en_i && !dead_q) begin
        ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
        if (step) begin
          pre_evt_o <= (cnt_q == pre_i);
          if (cnt_q == '0) begin
            timeout_o <= 1'b1;
            dead_q    <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (load_i && !dead_q) |=> (cnt_q == $past(tmo_i)));
endmodule

// File: rtl/wdg_boot.sv
module wdg_boot #(
  parameter int BOOT_TICKS = 524288
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic on_i,
  output logic expire_o
);
  localparam int BW = $clog2(BOOT_TICKS + 1);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (on_i && tick_i && !expire_o) begin
      if (cnt_q == BW'(BOOT_TICKS - 1)) expire_o <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r11_boot_needs_on: assert property (@(posedge clk) disable iff (rst)
    $rose(expire_o) |-> $past(on_i));
endmodule

// File: rtl/wdg_extrst.sv
module wdg_extrst #(
  parameter int STEP_TICKS  = 16384,
  parameter int BOOT_TICKS  = 524288,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slow_clk_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        int_rst_o,
  output logic        ext_rst_n_o,
  output logic        irq_o
);
  import wdg_pkg::*;

  logic     tick, pre_evt, tmo_evt, load, srq_fire, stat, boot_exp, ext_trip_q;
  wdg_cfg_t cfg;

  wdg_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .slow_i(slow_clk_i), .tick_o(tick));

  wdg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .tick_i(tick), .pre_evt_i(pre_evt), .cfg_o(cfg), .load_o(load),
    .srq_fire_o(srq_fire), .stat_o(stat));

  wdg_countdown #(.TMO_W(TMO_W), .STEP_TICKS(STEP_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .en_i(cfg.en), .load_i(load),
    .tmo_i(cfg.tmo), .pre_i(cfg.pre), .timeout_o(tmo_evt),
    .pre_evt_o(pre_evt));

  wdg_boot #(.BOOT_TICKS(BOOT_TICKS)) u_boot (
    .clk(clk), .rst(rst), .tick_i(tick), .on_i(cfg.boot_on),
    .expire_o(boot_exp));

  always_ff @(posedge clk) begin
    if (rst) begin
      int_rst_o   <= 1'b0;
      ext_trip_q  <= 1'b0;
      ext_rst_n_o <= 1'b1;
    end else begin
      int_rst_o   <= int_rst_o | (tmo_evt & ~cfg.route) | srq_fire;
      ext_trip_q  <= ext_trip_q | (tmo_evt & cfg.route) | boot_exp;
      ext_rst_n_o <= cfg.pin_n & ~ext_trip_q & ~(tmo_evt & cfg.route) & ~boot_exp;
    end
  end

  assign irq_o = stat & cfg.ie;

  a_r3_route_pin: assert property (@(posedge clk) disable iff (rst)
    (tmo_evt && cfg.route) |=> !ext_rst_n_o);
  a_r6_pin_drive: assert property (@(posedge clk) disable iff (rst)
    !cfg.pin_n |=> !ext_rst_n_o);
  a_r9_irq_with_timeout: assert property (@(posedge clk) disable iff (rst)
    (tmo_evt && !cfg.route && cfg.ie && cfg.pre == '0) |=> (irq_o && int_rst_o));
endmodule

// File: tb/wdg_extrst_test.sv
module wdg_extrst_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_clk = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        int_rst, ext_rst_n, irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  string       req_q[$];
  int          kind_q[$];
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;
  initial begin
    #5;
    forever #80 slow_clk = ~slow_clk;
  end

  wdg_extrst #(.STEP_TICKS(4), .BOOT_TICKS(200), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .slow_clk_i(slow_clk), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .int_rst_o(int_rst), .ext_rst_n_o(ext_rst_n), .irq_o(irq));

  // Monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      string r;
      int k;
      logic [15:0] e, a;
      r = req_q.pop_front();
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      case (k)
        0: a = {15'b0, int_rst};
        1: a = {15'b0, ext_rst_n};
        2: a = {15'b0, irq};
        default: a = rdata;
      endcase
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_sig(input string r, input int k, input logic [15:0] e);
    req_q.push_back(r);
    kind_q.push_back(k);
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string r, input logic [1:0] a, input logic [15:0] e);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    expect_sig(r, 3, e);
  endtask

  task automatic do_reset(input bit keep_boot);
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    if (!keep_boot) wr(2'd3, 16'h0000);
  endtask

  initial begin
    // R1 reset values
    do_reset(1'b1);
    expect_sig("R1", 0, 16'h0);
    expect_sig("R1", 1, 16'h1);
    expect_sig("R1", 2, 16'h0);
    rd_check("R1", 2'd0, 16'h000C);
    rd_check("R1", 2'd3, 16'h0001);

    // R2 internal timeout, T=3
    do_reset(1'b0);
    wr(2'd0, 16'h030D);
    wait_clk(112);
    expect_sig("R2", 0, 16'h0);
    wait_clk(40);
    expect_sig("R2", 0, 16'h1);
    expect_sig("R2", 1, 16'h1);

    // R8 write-once, R3 routed to pin, T=0
    do_reset(1'b0);
    wr(2'd0, 16'h000F);
    wr(2'd0, 16'h000C);
    rd_check("R8", 2'd0, 16'h000F);
    wait_clk(60);
    expect_sig("R3", 1, 16'h0);
    expect_sig("R3", 0, 16'h0);

    // R4 regular servicing keeps it alive
    do_reset(1'b0);
    wr(2'd0, 16'h030D);
    for (int i = 0; i < 4; i++) begin
      wait_clk(60);
      wr(2'd1, 16'h5555);
      wr(2'd1, 16'hAAAA);
    end
    expect_sig("R4", 0, 16'h0);
    wait_clk(100);
    expect_sig("R4", 0, 16'h0);
    wait_clk(60);
    expect_sig("R4", 0, 16'h1);

    // R5 broken key pair does not reload
    do_reset(1'b0);
    wr(2'd0, 16'h030D);
    wait_clk(60);
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'h1234);
    wr(2'd1, 16'hAAAA);
    wait_clk(85);
    expect_sig("R5", 0, 16'h1);

    // R6 direct pin drive
    do_reset(1'b0);
    wr(2'd0, 16'h0008);
    wait_clk(1);
    expect_sig("R6", 1, 16'h0);
    expect_sig("R6", 0, 16'h0);
    wr(2'd0, 16'h000C);
    wait_clk(1);
    expect_sig("R6", 1, 16'h1);

    // R7 software reset waits for next slow tick
    do_reset(1'b0);
    @(posedge slow_clk);
    repeat (4) @(posedge clk);
    wr(2'd0, 16'h0004);
    expect_sig("R7", 0, 16'h0);
    wr(2'd0, 16'h0004);
    wait_clk(10);
    expect_sig("R7", 0, 16'h1);

    // R9 pre-timeout P=2, T=5; R10 clear by writing 1
    do_reset(1'b0);
    wr(2'd2, 16'h8002);
    wr(2'd0, 16'h050D);
    wait_clk(96);
    expect_sig("R9", 2, 16'h0);
    wait_clk(54);
    expect_sig("R9", 2, 16'h1);
    expect_sig("R9", 0, 16'h0);
    wr(2'd2, 16'hC002);
    expect_sig("R10", 2, 16'h0);
    wait_clk(76);
    expect_sig("R10", 0, 16'h1);
    expect_sig("R10", 2, 16'h0);
    rd_check("R10", 2'd2, 16'h8002);

    // R9 P=0: interrupt together with reset
    do_reset(1'b0);
    wr(2'd2, 16'h8000);
    wr(2'd0, 16'h030D);
    wait_clk(112);
    expect_sig("R9", 2, 16'h0);
    wait_clk(40);
    expect_sig("R9", 2, 16'h1);
    expect_sig("R9", 0, 16'h1);

    // R11 boot watchdog left on
    do_reset(1'b1);
    wait_clk(1400);
    expect_sig("R11", 1, 16'h1);
    wait_clk(300);
    expect_sig("R11", 1, 16'h0);
    expect_sig("R11", 0, 16'h0);

    // R11 boot watchdog switched off, cannot be re-enabled
    do_reset(1'b0);
    wr(2'd3, 16'h0001);
    rd_check("R11", 2'd3, 16'h0000);
    wait_clk(1800);
    expect_sig("R11", 1, 16'h1);

    wait_clk(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule